// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a simple synchronous request port and an external asynchronous static RAM of 131072 bytes. A client raises a one-cycle request with a write flag, a 17-bit address and, for writes, a data byte. The controller then runs the RAM's pins through a fixed sequence of phases. When the access is complete it pulses a done flag, and for reads it presents the captured byte on a read-data register.

The RAM is enabled only when its low-active select is low and its high-active select is high. It has a low-active write strobe, a low-active output enable and one shared 8-bit data bus. Between accesses the controller holds the device deselected so that it stays in standby. It orders the output enable and its own bus drive so that the two sides never drive the bus together. The strobe width and the read access time are set by build parameters.

Top module: `sram_ctl`

## Requirements
- R1: After reset and whenever no access is in progress, the controller holds the low-active select at 1, the high-active select at 0, the write strobe at 1 and the output enable at 1, and done is 0.
- R2: A write request taken in idle produces the following phases, one clock each:
  - one setup cycle with the device selected, the strobe at 1, output enable at 1, and the address and write byte on the pins;
  - WR_PULSE cycles with the strobe at 0;
  - one hold cycle with the strobe back at 1 and address and data unchanged;
  - then idle, with done at 1.
- R3: From the setup cycle to the hold cycle of a write, the address pins do not change. The RAM stores the write byte at that address, and the byte is captured when the strobe rises.
- R4: A read request taken in idle selects the device for RD_WAIT cycles with output enable at 0 and the strobe at 1, with the address on the pins. The controller then returns to idle with done at 1. The read data then equals the byte on the bus in the last access cycle.
- R5: The controller drives the data bus only while output enable is 1. Output enable is never 0 while the strobe is 0.
- R6: In the cycle after any cycle with output enable at 0, the controller does not drive the bus.
- R7: A request raised while an access is in progress is ignored. The address pins stay unchanged, and no further access follows the current one.
- R8: The read data holds its value until the next read completes. A write leaves it unchanged.
- R9: Done is high for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access request, sampled in idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Access address |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Last byte read |
| done_o | output | 1 | One-cycle completion pulse |
| sram_addr_o | output | 17 | RAM address pins |
| sram_cs1_n_o | output | 1 | Low-active select |
| sram_cs2_o | output | 1 | High-active select |
| sram_we_n_o | output | 1 | Low-active write strobe |
| sram_oe_n_o | output | 1 | Low-active output enable |
| sram_dq_io | inout | 8 | Shared data bus |

## Verification
The assertions assume that the RAM drives the bus only while it is selected, with output enable at 0 and the strobe at 1. They also assume that the client changes its inputs only between clock edges. The bench model of the RAM keeps to the first assumption. The bench drives every input on the falling edge, so the second also holds. Requests raised during busy phases are allowed, and the bench issues them deliberately in order to check R7.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
    localparam int ADDR_W = 17;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_WSETUP  = 3'd1,
        PH_WSTROBE = 3'd2,
        PH_WHOLD   = 3'd3,
        PH_RACC    = 3'd4
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } op_t;

    typedef struct packed {
        logic cs1_n;
        logic cs2;
        logic we_n;
        logic oe_n;
        logic drv;
    } pin_ctl_t;

    function automatic pin_ctl_t decode_pins(phase_e ph);
        pin_ctl_t p;
        logic busy;
        busy    = (ph != PH_IDLE);
        p.cs1_n = !busy;
        p.cs2   = busy;
        p.we_n  = (ph != PH_WSTROBE);
        p.oe_n  = (ph != PH_RACC);
        p.drv   = (ph == PH_WSETUP) || (ph == PH_WSTROBE) || (ph == PH_WHOLD);
        return p;
    endfunction
endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int WR_PULSE = 2,
    parameter int RD_WAIT  = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req_i,
    input  logic   we_i,
    output phase_e phase_o,
    output logic   accept_o,
    output logic   finish_o,
    output logic   capture_o
);
    localparam int MAXW  = (WR_PULSE > RD_WAIT) ? WR_PULSE : RD_WAIT;
    localparam int CNT_W = $clog2(MAXW + 1);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    logic             cnt_zero;

    assign cnt_zero  = (cnt == '0);
    assign accept_o  = (phase == PH_IDLE) && req_i;
    assign capture_o = (phase == PH_RACC) && cnt_zero;
    assign finish_o  = (phase == PH_WHOLD) || capture_o;
    assign phase_o   = phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (req_i) begin
                    if (we_i) begin
                        phase <= PH_WSETUP;
                        cnt   <= '0;
                    end else begin
                        phase <= PH_RACC;
                        cnt   <= CNT_W'(RD_WAIT - 1);
                    end
                end
                PH_WSETUP: begin
                    phase <= PH_WSTROBE;
                    cnt   <= CNT_W'(WR_PULSE - 1);
                end
                PH_WSTROBE: begin
                    if (cnt_zero) phase <= PH_WHOLD;
                    else          cnt   <= cnt - 1'b1;
                end
                PH_WHOLD: phase <= PH_IDLE;
                PH_RACC: begin
                    if (cnt_zero) phase <= PH_IDLE;
                    else          cnt   <= cnt - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sram_ctl_req.sv
module sram_ctl_req
    import sram_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output op_t               op_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            op_o <= '0;
        end else if (accept_i) begin
            op_o.addr <= addr_i;
            op_o.data <= wdata_i;
        end
    end
endmodule

// File: rtl/sram_ctl_cap.sv
module sram_ctl_cap
    import sram_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_i,
    input  logic              finish_i,
    input  logic [DATA_W-1:0] bus_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_o <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= finish_i;
            if (capture_i) rdata_o <= bus_i;
        end
    end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int WR_PULSE = 2,
    parameter int RD_WAIT  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] sram_addr_o,
    output logic              sram_cs1_n_o,
    output logic              sram_cs2_o,
    output logic              sram_we_n_o,
    output logic              sram_oe_n_o,
    inout  wire  [DATA_W-1:0] sram_dq_io
);
    phase_e   phase;
    logic     accept;
    logic     finish;
    logic     capture;
    op_t      op;
    pin_ctl_t pins;
    logic     drv_en;

    sram_ctl_seq #(.WR_PULSE(WR_PULSE), .RD_WAIT(RD_WAIT)) u_seq (
        .clk(clk), .rst(rst), .req_i(req_i), .we_i(we_i),
        .phase_o(phase), .accept_o(accept), .finish_o(finish), .capture_o(capture)
    );

    sram_ctl_req u_req (
        .clk(clk), .rst(rst), .accept_i(accept),
        .addr_i(addr_i), .wdata_i(wdata_i), .op_o(op)
    );

    sram_ctl_cap u_cap (
        .clk(clk), .rst(rst), .capture_i(capture), .finish_i(finish),
        .bus_i(sram_dq_io), .rdata_o(rdata_o), .done_o(done_o)
    );

    assign pins         = decode_pins(phase);
    assign drv_en       = pins.drv;
    assign sram_addr_o  = op.addr;
    assign sram_cs1_n_o = pins.cs1_n;
    assign sram_cs2_o   = pins.cs2;
    assign sram_we_n_o  = pins.we_n;
    assign sram_oe_n_o  = pins.oe_n;
    assign sram_dq_io   = drv_en ? op.data : {DATA_W{1'bz}};
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk
    import sram_ctl_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic [ADDR_W-1:0] addr,
    input logic              cs1_n,
    input logic              cs2,
    input logic              we_n,
    input logic              oe_n,
    input logic              drv
);
    logic sel;
    assign sel = !cs1_n && cs2;

    a_r1_standby_idle: assert property (@(posedge clk) disable iff (rst)
        !sel |-> (we_n && oe_n && !drv && cs1_n && !cs2));

    a_r2_strobe_in_select: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (sel && $past(sel)));

    a_r3_addr_stable_write: assert property (@(posedge clk) disable iff (rst)
        $past(!we_n) |-> $stable(addr));

    a_r5_drive_only_oe_high: assert property (@(posedge clk) disable iff (rst)
        drv |-> oe_n);

    a_r5_no_oe_in_strobe: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> oe_n);

    a_r6_turnaround: assert property (@(posedge clk) disable iff (rst)
        $past(!oe_n) |-> !drv);

    a_r7_addr_held_busy: assert property (@(posedge clk) disable iff (rst)
        (sel && $past(sel)) |-> $stable(addr));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind sram_ctl sram_ctl_chk u_chk (
    .clk(clk), .rst(rst), .done(done_o), .addr(sram_addr_o),
    .cs1_n(sram_cs1_n_o), .cs2(sram_cs2_o), .we_n(sram_we_n_o),
    .oe_n(sram_oe_n_o), .drv(drv_en)
);

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;
    localparam int WRP = 2;
    localparam int RDW = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        done;
    logic [16:0] s_addr;
    logic        cs1_n, cs2, we_n, oe_n;
    wire  [7:0]  dq;

    int n_chk = 0;
    int n_fail = 0;
    int addr_err = 0;
    logic [7:0] ref_mem [int];
    logic [7:0] last_rd = 8'h00;

    always #2 clk = ~clk;

    sram_ctl #(.WR_PULSE(WRP), .RD_WAIT(RDW)) u_dut (
        .clk(clk), .rst(rst), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .sram_addr_o(s_addr),
        .sram_cs1_n_o(cs1_n), .sram_cs2_o(cs2), .sram_we_n_o(we_n),
        .sram_oe_n_o(oe_n), .sram_dq_io(dq)
    );

    // Behavioural RAM: drives on read, stores when the write overlap ends.
    logic [7:0] mdl_mem [int];
    logic [7:0] mdl_q = 8'h00;
    logic       mdl_drv;
    logic       prev_wr = 1'b0;
    logic [16:0] prev_a = '0;
    logic [7:0]  prev_d = '0;
    assign mdl_drv = !cs1_n && cs2 && we_n && !oe_n;
    assign dq = mdl_drv ? mdl_q : 8'bz;

    always @(negedge clk) begin
        logic cur_wr;
        cur_wr = !cs1_n && cs2 && !we_n;
        if (prev_wr && !cur_wr) mdl_mem[int'(prev_a)] = prev_d;
        if (prev_wr && cur_wr && (s_addr != prev_a)) addr_err++;
        prev_wr = cur_wr;
        prev_a  = s_addr;
        prev_d  = dq;
        mdl_q   = mdl_mem.exists(int'(s_addr)) ? mdl_mem[int'(s_addr)] : 8'h00;
    end

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // Compare one cycle of pins against the expected values.
    task automatic cyc(string r, bit sel, bit e_we_n, bit e_oe_n, logic [16:0] a,
                       bit drive, logic [7:0] d, bit e_done);
        chk(r, {27'd0, cs1_n, cs2, we_n, oe_n, done}, {27'd0, !sel, sel, e_we_n, e_oe_n, e_done});
        if (sel) chk(r, {15'd0, s_addr}, {15'd0, a});
        if (drive) chk(r, {24'd0, dq}, {24'd0, d});
    endtask

    function automatic logic [7:0] ref_rd(logic [16:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
    endfunction

    // Called at a falling edge in idle; returns at a falling edge in idle.
    task automatic op(bit w, logic [16:0] a, logic [7:0] d, bit poke);
        req = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        if (w) begin
            cyc("R2 setup", 1, 1, 1, a, 1, d, 0);
            for (int i = 0; i < WRP; i++) begin
                @(negedge clk);
                req = 1'b0;
                cyc("R2 strobe", 1, 0, 1, a, 1, d, 0);
                if (poke && i == 0) begin
                    req = 1'b1; we = 1'b1; addr = a ^ 17'h1; wdata = ~d;
                end
            end
            @(negedge clk);
            req = 1'b0;
            cyc("R3 hold", 1, 1, 1, a, 1, d, 0);
            ref_mem[int'(a)] = d;
            @(negedge clk);
            cyc("R2 done", 0, 1, 1, a, 0, d, 1);
            chk("R8 rdata kept over write", {24'd0, rdata}, {24'd0, last_rd});
        end else begin
            for (int i = 0; i < RDW; i++) begin
                if (i > 0) @(negedge clk);
                req = 1'b0;
                cyc("R4 access", 1, 1, 0, a, 0, 8'h00, 0);
                if (poke && i == 0) begin
                    req = 1'b1; we = 1'b1; addr = a ^ 17'h2; wdata = 8'hEE;
                end
            end
            @(negedge clk);
            req = 1'b0;
            cyc("R4 done", 0, 1, 1, a, 0, 8'h00, 1);
            last_rd = ref_rd(a);
            chk("R4 rdata", {24'd0, rdata}, {24'd0, last_rd});
        end
        @(negedge clk);
        cyc("R9 done drops / R7 no extra access", 0, 1, 1, a, 0, 8'h00, 0);
        chk("R8 rdata held", {24'd0, rdata}, {24'd0, last_rd});
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 50000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: standby after reset
        cyc("R1 reset", 0, 1, 1, '0, 0, 8'h00, 0);
        chk("R1 rdata reset", {24'd0, rdata}, 32'd0);
        repeat (2) @(negedge clk);
        cyc("R1 idle", 0, 1, 1, '0, 0, 8'h00, 0);

        op(1, 17'h00000, 8'h5A, 0);
        op(1, 17'h1FFFF, 8'hA5, 0);
        op(1, 17'h12345, 8'h3C, 0);
        op(0, 17'h00000, 8'h00, 0);
        op(0, 17'h1FFFF, 8'h00, 0);
        op(0, 17'h12345, 8'h00, 0);
        op(0, 17'h0ABCD, 8'h00, 0);
        // back-to-back turnaround: read then write then read (R6)
        op(0, 17'h1FFFF, 8'h00, 0);
        op(1, 17'h1FFFF, 8'hC3, 0);
        op(0, 17'h1FFFF, 8'h00, 0);
        // R7: requests raised while busy are ignored
        op(1, 17'h00100, 8'h77, 1);
        op(0, 17'h00101, 8'h00, 0);
        op(0, 17'h00100, 8'h00, 1);
        op(0, 17'h00102, 8'h00, 0);
        for (int k = 0; k < 8; k++) op(1, 17'(k * 4099), 8'(k * 37 + 1), 0);
        for (int k = 0; k < 8; k++) op(0, 17'(k * 4099), 8'h00, 0);
        repeat (3) @(negedge clk);
        cyc("R1 final idle", 0, 1, 1, '0, 0, 8'h00, 0);
        chk("R3 address moved during strobe", addr_err, 0);
        finish_run();
    end
endmodule